// File: doc/BRIEF.md
# Framebuffer Pixel Unpacker

This block sits between a framebuffer fetch engine and a display timing generator. It takes 32-bit memory words over a valid/ready input and turns each one into one or two pixels on a valid/ready output. The pixels are laid out for a parallel display bus that is 16, 18 or 24 bits wide. Two memory layouts are handled. In the first, each word holds two 5-6-5 pixels in its half-words. In the second, each word holds a single 8-8-8 pixel in its low three bytes, and the top byte carries no colour.

A per-byte enable mask is applied as each word is captured. A byte with its enable bit clear reads as zero. A 5-6-5 pixel that goes onto a wider bus has each colour widened by repeating its top bits. An 8-8-8 pixel that goes onto a narrower bus has each colour cut down to its top bits. Configuration is static while traffic flows. An unsupported layout code holds both handshakes low.

Top module: `pixel_unpacker`

## Requirements
- R1: After reset, pixValid is 0, and inReady is 1 whenever the layout code is supported.
- R2: With layoutSel = 0, each accepted word yields two pixels: first from bits [15:0], then from bits [31:16]. Each half-word is red [15:11], green [10:5], blue [4:0].
- R3: With layoutSel = 3, each accepted word yields one pixel, taken from red [23:16], green [15:8] and blue [7:0].
- R4: Bit i of byteEn gates byte i (bits [8i+7:8i]) of the captured word. A byte whose enable bit is 0 contributes zeros to the pixel.
- R5: With busSel = 1 (16-bit bus), pixData is {8'b0, R5, G6, B5}. 5-6-5 pixels pass through unchanged. An 8-bit colour keeps its top 5 bits for red and blue and its top 6 bits for green.
- R6: With busSel = 2 (18-bit bus), pixData is {6'b0, R6, G6, B6}. A 5-bit colour becomes {c, c[4]}. An 8-bit colour keeps its top 6 bits.
- R7: With busSel = 0 (the unconfigured default) or 3, the bus is 24 bits: pixData is {R8, G8, B8}. A 5-bit colour becomes {c, c[4:2]} and a 6-bit colour becomes {c, c[5:4]}.
- R8: With layoutSel = 1 or 2, inReady and pixValid are both 0, and offered words are not consumed.
- R9: inReady is 1 only when no pixel of the held word is still waiting, so inReady and pixValid are never both 1.
- R10: While pixValid is 1 and pixReady is 0, pixValid stays 1 and pixData holds its value on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| layoutSel | input | 2 | Memory layout code: 0 = two 5-6-5 pixels per word, 3 = one 8-8-8 pixel per word |
| byteEn | input | 4 | Per-byte enable for captured words |
| busSel | input | 2 | Output bus width: 1 = 16, 2 = 18, 0 or 3 = 24 |
| inValid | input | 1 | Word offered |
| inData | input | 32 | Framebuffer word |
| inReady | output | 1 | Word can be taken |
| pixValid | output | 1 | Pixel available |
| pixData | output | 24 | Pixel formatted for the selected bus, right aligned |
| pixReady | input | 1 | Downstream takes the pixel |

## Verification
The bench runs every combination of layout, several byte-enable masks and all four bus codes. Downstream back-pressure is random, so a half-word order mix-up would show up as swapped pixels, and a wrong colour-replication rule would show up as mismatched low bits. An unsupported layout code is held for a stretch of cycles while a word is offered. A design that consumed that word would shift every pixel that follows. Stalls are checked for held data, and every cycle is checked for an overlap of inReady and pixValid. A design that refilled early would drop the second half-word.

// File: rtl/upk_pkg.sv
package upk_pkg;
  localparam int WORD_W   = 32;
  localparam int BYTE_W   = 8;
  localparam int N_BYTES  = WORD_W / BYTE_W;
  localparam int HALF_W   = WORD_W / 2;
  localparam int COLOR_W  = 8;
  localparam int PIX_W    = 3 * COLOR_W;

  localparam logic [1:0] LAYOUT_HALF = 2'd0;
  localparam logic [1:0] LAYOUT_FULL = 2'd3;

  localparam logic [1:0] BUS_DEFAULT = 2'd0;
  localparam logic [1:0] BUS_16      = 2'd1;
  localparam logic [1:0] BUS_18      = 2'd2;
  localparam logic [1:0] BUS_24      = 2'd3;

  typedef struct packed {
    logic load;
    logic upperSel;
  } upkStrobe_t;
endpackage

// File: rtl/upk_ctrl.sv
module upk_ctrl
  import upk_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] layoutSel,
  input  logic       inValid,
  output logic       inReady,
  output logic       pixValid,
  input  logic       pixReady,
  output upkStrobe_t strobe
);
  logic full, upper;
  logic halfMode, modeOk, pixFire, lastPix;

  assign halfMode = (layoutSel == LAYOUT_HALF);
  assign modeOk   = halfMode || (layoutSel == LAYOUT_FULL);
  assign inReady  = modeOk && !full;
  assign pixValid = modeOk && full;
  assign pixFire  = pixValid && pixReady;
  assign lastPix  = !halfMode || upper;

  assign strobe.load     = inValid && inReady;
  assign strobe.upperSel = upper;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full  <= 1'b0;
      upper <= 1'b0;
    end else if (strobe.load) begin
      full  <= 1'b1;
      upper <= 1'b0;
    end else if (pixFire) begin
      if (lastPix) begin
        full  <= 1'b0;
        upper <= 1'b0;
      end else begin
        upper <= 1'b1;
      end
    end
  end

  // R9
  a_r9_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    pixValid |-> !inReady);
  // R8
  a_r8_bad_code_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !modeOk |-> (!inReady && !pixValid));
  // R2
  a_r2_second_half_follows: assert property (@(posedge clk) disable iff (!rst_n)
    (pixFire && halfMode && !upper) |=> (pixValid || !modeOk));
  // R3
  a_r3_one_pixel_per_word: assert property (@(posedge clk) disable iff (!rst_n)
    (pixFire && layoutSel == LAYOUT_FULL) |=> !pixValid);
endmodule

// File: rtl/upk_datapath.sv
module upk_datapath
  import upk_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  upkStrobe_t          strobe,
  input  logic [WORD_W-1:0]   inData,
  input  logic [N_BYTES-1:0]  byteEn,
  input  logic [1:0]          layoutSel,
  input  logic [1:0]          busSel,
  output logic [PIX_W-1:0]    pixData
);
  logic [WORD_W-1:0]  gatedIn;
  logic [WORD_W-1:0]  wordReg;
  logic [HALF_W-1:0]  halfWord;
  logic [COLOR_W-1:0] red, green, blue;

  for (genvar b = 0; b < N_BYTES; b++) begin : g_byteGate
    assign gatedIn[b*BYTE_W +: BYTE_W] = inData[b*BYTE_W +: BYTE_W] & {BYTE_W{byteEn[b]}};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           wordReg <= '0;
    else if (strobe.load) wordReg <= gatedIn;
  end

  assign halfWord = strobe.upperSel ? wordReg[WORD_W-1:HALF_W] : wordReg[HALF_W-1:0];

  // Expand every source pixel to 8-8-8 first; narrowing then only keeps top bits.
  always_comb begin
    if (layoutSel == LAYOUT_HALF) begin
      red   = {halfWord[15:11], halfWord[15:13]};
      green = {halfWord[10:5],  halfWord[10:9]};
      blue  = {halfWord[4:0],   halfWord[4:2]};
    end else begin
      red   = wordReg[23:16];
      green = wordReg[15:8];
      blue  = wordReg[7:0];
    end
  end

  always_comb begin
    case (busSel)
      BUS_16:  pixData = {8'd0, red[7:3], green[7:2], blue[7:3]};
      BUS_18:  pixData = {6'd0, red[7:2], green[7:2], blue[7:2]};
      default: pixData = {red, green, blue};
    endcase
  end
endmodule

// File: rtl/pixel_unpacker.sv
module pixel_unpacker
  import upk_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        layoutSel,
  input  logic [N_BYTES-1:0] byteEn,
  input  logic [1:0]        busSel,
  input  logic              inValid,
  input  logic [WORD_W-1:0] inData,
  output logic              inReady,
  output logic              pixValid,
  output logic [PIX_W-1:0]  pixData,
  input  logic              pixReady
);
  upkStrobe_t strobe;

  upk_ctrl ctrl_i (
    .clk(clk), .rst_n(rst_n), .layoutSel(layoutSel),
    .inValid(inValid), .inReady(inReady),
    .pixValid(pixValid), .pixReady(pixReady), .strobe(strobe)
  );

  upk_datapath dp_i (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .inData(inData),
    .byteEn(byteEn), .layoutSel(layoutSel), .busSel(busSel), .pixData(pixData)
  );

  // R10
  a_r10_hold_on_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (pixValid && !pixReady) |=> (pixValid && $stable(pixData)));
endmodule

// File: tb/pixel_unpacker_tb.sv
module pixel_unpacker_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  layoutSel = 2'd0;
  logic [3:0]  byteEn = 4'hF;
  logic [1:0]  busSel = 2'd0;
  logic        inValid = 1'b0;
  logic [31:0] inData = '0;
  logic        inReady, pixValid, pixReady;
  logic [23:0] pixData;

  always #5 clk = ~clk;

  pixel_unpacker dut_i (
    .clk(clk), .rst_n(rst_n), .layoutSel(layoutSel), .byteEn(byteEn),
    .busSel(busSel), .inValid(inValid), .inData(inData), .inReady(inReady),
    .pixValid(pixValid), .pixData(pixData), .pixReady(pixReady)
  );

  int checks = 0;
  int errors = 0;
  logic [23:0] expQ[$];
  logic [31:0] rng = 32'h1234_5678;
  logic [31:0] curWord = 32'hA5C3_1E7B;
  int wordsLeft = 0;
  bit holdPrev = 0;
  logic [23:0] holdData = '0;
  string tag = "";

  task automatic chk(input bit ok, input string req, input logic [23:0] act, input logic [23:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] nextRng(input logic [31:0] x);
    logic [31:0] y = x;
    y ^= y << 13; y ^= y >> 17; y ^= y << 5;
    return y;
  endfunction

  // Reference from requirements R2..R7.
  function automatic logic [23:0] refPix(input logic [31:0] w, input logic [3:0] m,
      input logic [1:0] wl, input logic [1:0] bw, input bit upperHalf);
    logic [31:0] mw;
    logic [15:0] h;
    logic [4:0] r5, b5;
    logic [5:0] g6;
    logic [7:0] r8, g8, b8;
    for (int i = 0; i < 4; i++) mw[8*i +: 8] = m[i] ? w[8*i +: 8] : 8'h00;
    if (wl == 2'd0) begin
      h  = upperHalf ? mw[31:16] : mw[15:0];
      r5 = h[15:11]; g6 = h[10:5]; b5 = h[4:0];
      case (bw)
        2'd1:    return {8'h00, h};
        2'd2:    return {6'h00, r5, r5[4], g6, b5, b5[4]};
        default: return {r5, r5[4:2], g6, g6[5:4], b5, b5[4:2]};
      endcase
    end else begin
      r8 = mw[23:16]; g8 = mw[15:8]; b8 = mw[7:0];
      case (bw)
        2'd1:    return {8'h00, r8[7:3], g8[7:2], b8[7:3]};
        2'd2:    return {6'h00, r8[7:2], g8[7:2], b8[7:2]};
        default: return {r8, g8, b8};
      endcase
    end
  endfunction

  function automatic string cfgTag(input logic [1:0] wl, input logic [3:0] m, input logic [1:0] bw);
    string s;
    s = (wl == 2'd0) ? "R2" : "R3";
    if (m != 4'hF && m != 4'h7) s = {s, " R4"};
    case (bw)
      2'd1:    s = {s, " R5"};
      2'd2:    s = {s, " R6"};
      default: s = {s, " R7"};
    endcase
    return s;
  endfunction

  task automatic step(input bit wantIn, input bit rdy);
    @(negedge clk);
    if (holdPrev)
      chk(pixValid === 1'b1 && pixData === holdData, "R10 stall hold", pixData, holdData);
    if (pixValid === 1'b1)
      chk(inReady === 1'b0, "R9 ready while pixel pending", {23'd0, inReady}, 24'd0);
    pixReady = rdy;
    inValid  = wantIn;
    inData   = curWord;
    if (pixValid === 1'b1 && rdy) begin
      if (expQ.size() == 0) chk(1'b0, {tag, " unexpected pixel"}, pixData, 24'hxxxxxx);
      else begin
        logic [23:0] e;
        e = expQ.pop_front();
        chk(pixData === e, tag, pixData, e);
      end
    end
    if (wantIn && inReady === 1'b1) begin
      if (layoutSel == 2'd0) begin
        expQ.push_back(refPix(curWord, byteEn, layoutSel, busSel, 1'b0));
        expQ.push_back(refPix(curWord, byteEn, layoutSel, busSel, 1'b1));
      end else begin
        expQ.push_back(refPix(curWord, byteEn, layoutSel, busSel, 1'b0));
      end
      rng = nextRng(rng);
      curWord = rng;
      wordsLeft--;
    end
    holdPrev = (pixValid === 1'b1) && !rdy;
    holdData = pixData;
  endtask

  task automatic runSegment(input logic [1:0] wl, input logic [3:0] m, input logic [1:0] bw, input bit busy);
    @(negedge clk);
    layoutSel = wl; byteEn = m; busSel = bw;
    tag = cfgTag(wl, m, bw);
    wordsLeft = 12;
    while (wordsLeft > 0 || expQ.size() != 0) begin
      rng = nextRng(rng);
      step(wordsLeft > 0 && rng[3:0] != 4'd0, busy ? (rng[9:8] != 2'b00) : rng[12]);
    end
    step(1'b0, 1'b1);
    chk(pixValid === 1'b0, {tag, " drained"}, {23'd0, pixValid}, 24'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog R1..: actual=timeout expected=completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    pixReady = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    chk(pixValid === 1'b0, "R1 pixValid after reset", {23'd0, pixValid}, 24'd0);
    chk(inReady === 1'b1, "R1 inReady after reset", {23'd0, inReady}, 24'd1);

    // Directed: known 5-6-5 pair on 24-bit default bus (R2, R7)
    @(negedge clk);
    layoutSel = 2'd0; byteEn = 4'hF; busSel = 2'd0;
    tag = "R2 R7 directed";
    curWord = 32'hF800_07FF;
    wordsLeft = 1;
    step(1'b1, 1'b0);
    while (expQ.size() != 0) step(1'b0, 1'b1);
    chk(expQ.size() == 0, "R2 directed pair", 24'd0, 24'd0);

    foreach (expQ[i]) expQ.delete(i);
    for (int wlI = 0; wlI < 2; wlI++) begin
      for (int mI = 0; mI < 3; mI++) begin
        for (int bw = 0; bw < 4; bw++) begin
          logic [3:0] mm;
          mm = (mI == 0) ? 4'hF : (mI == 1) ? 4'h7 : 4'h5;
          runSegment(wlI == 0 ? 2'd0 : 2'd3, mm, bw[1:0], bw[0]);
        end
      end
    end

    // R8: unsupported codes hold both handshakes low while a word is offered
    for (int code = 1; code < 3; code++) begin
      @(negedge clk);
      layoutSel = code[1:0]; busSel = 2'd3; byteEn = 4'hF;
      inValid = 1'b1; pixReady = 1'b1; inData = 32'hDEAD_BEEF;
      for (int c = 0; c < 8; c++) begin
        @(negedge clk);
        chk(inReady === 1'b0, "R8 inReady with bad code", {23'd0, inReady}, 24'd0);
        chk(pixValid === 1'b0, "R8 pixValid with bad code", {23'd0, pixValid}, 24'd0);
      end
      inValid = 1'b0;
    end
    // After returning to a good code, only newly accepted words emerge (R8)
    holdPrev = 0;
    runSegment(2'd3, 4'hF, 2'd3, 1'b1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule